// File: doc/BRIEF.md
# Cache Tag Array Access Port

This block lets privileged software inspect and rewrite the tag array of a four-way set-associative write-back cache through a memory-mapped window. A one-cycle request strobe carries a 32-bit address, a direction, an access size, a fetch marker and, for writes, a 32-bit data word. When the top address byte is 0xF0, the block claims the access. From the address it takes the entry index, the way number and an associative-enable bit.

A read returns the raw contents of the addressed entry in one word: the tag, the replacement-order (LRU) bits, the dirty flag U and the valid flag V. No tag comparison takes place. A non-associative write replaces those fields. If the line being replaced is both dirty and valid, the block first asks an external engine to write the line back. It holds the bus response until that engine acknowledges, and only then updates the entry. Accesses that are not longword, instruction fetches, and associative writes are answered with an error and change nothing.

Top module: `cache_tag_port`

## Requirements
- R1: After reset every entry of every way reads back as zero, and bus_ready, bus_err and wb_req are low.
- R2: A strobe whose address top byte is not 0xF0 (including the 0xF1 data window) gets no bus_ready and changes no entry.
- R3: A claimed access with bus_size other than 2'b10 (00 byte, 01 word, 11 reserved) or with bus_fetch high is answered one cycle later with bus_ready and bus_err high. It leaves the array unchanged.
- R4: A claimed longword read raises bus_ready one cycle after the strobe. bus_rdata = {tag[31:10], lru[9:4], 2'b00, U[1], V[0]} of the entry picked by index address bits 11:4 and way bits 13:12 (codes 00, 01, 10, 11 select ways 0 to 3). The value is the same whether address bit 3 (A) is 0 or 1.
- R5: A longword write with A=0 to an entry that is not both dirty and valid stores tag from wdata[31:10], LRU from wdata[9:4], U from wdata[1] and V from wdata[0]. bus_ready comes one cycle later with bus_err low.
- R6: Tag bits 31:29 are always stored as zero, whatever the write data holds.
- R7: A write with V=0 stores U=0.
- R8: A write with A=1 is answered one cycle later with bus_ready and bus_err high and leaves the array unchanged.
- R9: A write to an entry with U=1 and V=1 raises wb_req one cycle after the strobe. wb_tag, wb_index and wb_way carry the old tag and the entry's position and hold steady while bus_ready stays low, until wb_ack.
- R10: The cycle after wb_ack is sampled, wb_req is low. On the next edge the entry takes the new fields and bus_ready rises with bus_err low.
- R11: Strobes that arrive while a write-back is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | One-cycle access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_fetch | input | 1 | Access is an instruction fetch |
| bus_size | input | 2 | 00 byte, 01 word, 10 longword, 11 reserved |
| bus_addr | input | 32 | Access address |
| bus_wdata | input | 32 | Write data word |
| bus_ready | output | 1 | One-cycle response pulse |
| bus_err | output | 1 | Response is an error |
| bus_rdata | output | 32 | Read data, zero on write and error responses |
| wb_req | output | 1 | Write-back of the old line requested |
| wb_tag | output | 22 | Tag of the line to write back |
| wb_index | output | 8 | Entry index of the line to write back |
| wb_way | output | 2 | Way of the line to write back |
| wb_ack | input | 1 | Write-back finished |

## Verification
Reads, error responses and clean writes answer on the first edge after the strobe. The bench drives each strobe on a falling edge and samples the response on the next falling edge. A write to a dirty, valid line shows wb_req at that same sampling point. After the bench raises wb_ack, it looks one falling edge later for wb_req low and bus_ready still low, then one more edge later for the response. Effects on the array are always confirmed by a separate read through the same window.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

    localparam int TAG_W = 22;
    localparam int LRU_W = 6;
    localparam logic [1:0] SIZE_LONG = 2'b10;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [LRU_W-1:0] lru;
        logic             dirty;
        logic             valid;
    } tag_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WB_WAIT = 2'd1,
        ST_UPDATE  = 2'd2
    } ctrl_state_t;

    // Field extraction from a write word; top three tag bits forced to zero,
    // dirty flag dropped when the line is marked invalid.
    function automatic tag_entry_t entry_from_word(input logic [31:0] w);
        tag_entry_t e;
        e.tag   = {3'b000, w[28:10]};
        e.lru   = w[9:4];
        e.valid = w[0];
        e.dirty = w[1] & w[0];
        return e;
    endfunction

    function automatic logic [31:0] word_from_entry(input tag_entry_t e);
        return {e.tag, e.lru, 2'b00, e.dirty, e.valid};
    endfunction

endpackage

// File: rtl/cache_tag_decode.sv
module cache_tag_decode #(
    parameter int          IDX_W     = 8,
    parameter int          WAY_W     = 2,
    parameter int          OFF_W     = 4,
    parameter int          ASSOC_BIT = 3,
    parameter logic [7:0]  WIN_BYTE  = 8'hF0
) (
    input  logic [31:0]      addr,
    input  logic [1:0]       size,
    input  logic             fetch,
    input  logic             write,
    output logic             in_window,
    output logic             bad_access,
    output logic [IDX_W-1:0] idx,
    output logic [WAY_W-1:0] way
);
    import cache_tag_pkg::*;

    localparam int IDX_LO = OFF_W;
    localparam int WAY_LO = OFF_W + IDX_W;

    logic assoc;

    always_comb begin
        in_window  = (addr[31:24] == WIN_BYTE);
        idx        = addr[IDX_LO +: IDX_W];
        way        = addr[WAY_LO +: WAY_W];
        assoc      = addr[ASSOC_BIT];
        bad_access = (size != SIZE_LONG) || fetch || (write && assoc);
    end

endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int WAYS    = 4,
    parameter int ENTRIES = 256,
    parameter int IDX_W   = 8,
    parameter int WAY_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [WAY_W-1:0]              rd_way,
    input  logic [IDX_W-1:0]              rd_idx,
    output cache_tag_pkg::tag_entry_t     rd_entry,
    input  logic                          wr_en,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic [IDX_W-1:0]              wr_idx,
    input  cache_tag_pkg::tag_entry_t     wr_entry
);
    import cache_tag_pkg::*;

    tag_entry_t way_rd [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tag_entry_t mem_q [ENTRIES];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    mem_q[i] <= '0;
                end
            end else if (wr_en && (wr_way == WAY_W'(w))) begin
                mem_q[wr_idx] <= wr_entry;
            end
        end

        assign way_rd[w] = mem_q[rd_idx];
    end

    assign rd_entry = way_rd[rd_way];

endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl #(
    parameter int IDX_W = 8,
    parameter int WAY_W = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req,
    input  logic                          write,
    input  logic                          in_window,
    input  logic                          bad_access,
    input  logic [IDX_W-1:0]              idx,
    input  logic [WAY_W-1:0]              way,
    input  logic [31:0]                   wdata,
    input  cache_tag_pkg::tag_entry_t     cur_entry,
    input  logic                          wb_ack,
    output logic                          wr_en,
    output logic [WAY_W-1:0]              wr_way,
    output logic [IDX_W-1:0]              wr_idx,
    output cache_tag_pkg::tag_entry_t     wr_entry,
    output logic                          ready,
    output logic                          err,
    output logic [31:0]                   rdata,
    output logic                          wb_req,
    output logic [cache_tag_pkg::TAG_W-1:0] wb_tag,
    output logic [IDX_W-1:0]              wb_idx,
    output logic [WAY_W-1:0]              wb_way
);
    import cache_tag_pkg::*;

    typedef struct packed {
        ctrl_state_t      state;
        logic             ready;
        logic             err;
        logic [31:0]      rdata;
        logic             wb_req;
        logic [TAG_W-1:0] wb_tag;
        logic [IDX_W-1:0] p_idx;
        logic [WAY_W-1:0] p_way;
        tag_entry_t       p_entry;
    } ctrl_regs_t;

    ctrl_regs_t d, q;

    always_comb begin
        d          = q;
        d.ready    = 1'b0;
        d.err      = 1'b0;
        d.rdata    = '0;
        wr_en      = 1'b0;
        wr_way     = way;
        wr_idx     = idx;
        wr_entry   = entry_from_word(wdata);
        unique case (q.state)
            ST_IDLE: begin
                if (req && in_window) begin
                    if (bad_access) begin
                        d.ready = 1'b1;
                        d.err   = 1'b1;
                    end else if (!write) begin
                        d.ready = 1'b1;
                        d.rdata = word_from_entry(cur_entry);
                    end else if (cur_entry.dirty && cur_entry.valid) begin
                        d.state   = ST_WB_WAIT;
                        d.wb_req  = 1'b1;
                        d.wb_tag  = cur_entry.tag;
                        d.p_idx   = idx;
                        d.p_way   = way;
                        d.p_entry = entry_from_word(wdata);
                    end else begin
                        wr_en   = 1'b1;
                        d.ready = 1'b1;
                    end
                end
            end
            ST_WB_WAIT: begin
                if (wb_ack) begin
                    d.wb_req = 1'b0;
                    d.state  = ST_UPDATE;
                end
            end
            ST_UPDATE: begin
                wr_en    = 1'b1;
                wr_way   = q.p_way;
                wr_idx   = q.p_idx;
                wr_entry = q.p_entry;
                d.ready  = 1'b1;
                d.state  = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign ready  = q.ready;
    assign err    = q.err;
    assign rdata  = q.rdata;
    assign wb_req = q.wb_req;
    assign wb_tag = q.wb_tag;
    assign wb_idx = q.p_idx;
    assign wb_way = q.p_way;

endmodule

// File: rtl/cache_tag_port.sv
module cache_tag_port #(
    parameter int WAYS    = 4,
    parameter int ENTRIES = 256,
    parameter int OFF_W   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_req,
    input  logic                            bus_write,
    input  logic                            bus_fetch,
    input  logic [1:0]                      bus_size,
    input  logic [31:0]                     bus_addr,
    input  logic [31:0]                     bus_wdata,
    output logic                            bus_ready,
    output logic                            bus_err,
    output logic [31:0]                     bus_rdata,
    output logic                            wb_req,
    output logic [cache_tag_pkg::TAG_W-1:0] wb_tag,
    output logic [$clog2(ENTRIES)-1:0]      wb_index,
    output logic [$clog2(WAYS)-1:0]         wb_way,
    input  logic                            wb_ack
);
    import cache_tag_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int WAY_W = $clog2(WAYS);

    logic             in_window, bad_access;
    logic [IDX_W-1:0] dec_idx, wr_idx;
    logic [WAY_W-1:0] dec_way, wr_way;
    logic             wr_en;
    tag_entry_t       cur_entry, wr_entry;

    cache_tag_decode #(
        .IDX_W(IDX_W), .WAY_W(WAY_W), .OFF_W(OFF_W), .ASSOC_BIT(3), .WIN_BYTE(8'hF0)
    ) u_decode (
        .addr(bus_addr), .size(bus_size), .fetch(bus_fetch), .write(bus_write),
        .in_window(in_window), .bad_access(bad_access), .idx(dec_idx), .way(dec_way)
    );

    cache_tag_store #(
        .WAYS(WAYS), .ENTRIES(ENTRIES), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_way(dec_way), .rd_idx(dec_idx), .rd_entry(cur_entry),
        .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx), .wr_entry(wr_entry)
    );

    cache_tag_ctrl #(
        .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req(bus_req), .write(bus_write), .in_window(in_window), .bad_access(bad_access),
        .idx(dec_idx), .way(dec_way), .wdata(bus_wdata), .cur_entry(cur_entry),
        .wb_ack(wb_ack),
        .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx), .wr_entry(wr_entry),
        .ready(bus_ready), .err(bus_err), .rdata(bus_rdata),
        .wb_req(wb_req), .wb_tag(wb_tag), .wb_idx(wb_index), .wb_way(wb_way)
    );

endmodule

// File: rtl/cache_tag_port_chk.sv
module cache_tag_port_chk #(
    parameter int IDX_W = 8,
    parameter int WAY_W = 2,
    parameter int TAG_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_ready,
    input logic             bus_err,
    input logic [31:0]      bus_rdata,
    input logic             wb_req,
    input logic [TAG_W-1:0] wb_tag,
    input logic [IDX_W-1:0] wb_index,
    input logic [WAY_W-1:0] wb_way,
    input logic             wb_ack
);

    assert_err_has_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ready);

    assert_tag_top_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> (bus_rdata[31:29] == 3'b000));

    assert_dirty_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> !(bus_rdata[1] && !bus_rdata[0]));

    assert_no_ready_in_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !bus_ready);

    assert_wb_fields_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_tag) && $stable(wb_index) && $stable(wb_way)));

    assert_ack_then_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && wb_ack) |=> (!wb_req && !bus_ready) ##1 (bus_ready && !bus_err));

endmodule

bind cache_tag_port cache_tag_port_chk #(
    .IDX_W($clog2(ENTRIES)), .WAY_W($clog2(WAYS)), .TAG_W(cache_tag_pkg::TAG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready), .bus_err(bus_err),
    .bus_rdata(bus_rdata), .wb_req(wb_req), .wb_tag(wb_tag),
    .wb_index(wb_index), .wb_way(wb_way), .wb_ack(wb_ack)
);

// File: tb/cache_tag_port_test.sv
module cache_tag_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_write = 1'b0, bus_fetch = 1'b0;
    logic [1:0]  bus_size = 2'b10;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic        bus_ready, bus_err, wb_req;
    logic [31:0] bus_rdata;
    logic [21:0] wb_tag;
    logic [7:0]  wb_index;
    logic [1:0]  wb_way;
    logic        wb_ack = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2 clk = ~clk;

    cache_tag_port uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_write(bus_write),
        .bus_fetch(bus_fetch), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_err(bus_err),
        .bus_rdata(bus_rdata), .wb_req(wb_req), .wb_tag(wb_tag),
        .wb_index(wb_index), .wb_way(wb_way), .wb_ack(wb_ack)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [31:0] taddr(input logic [1:0] way, input logic [7:0] idx, input logic a);
        return {8'hF0, 10'd0, way, idx, a, 3'b000};
    endfunction

    function automatic logic [31:0] expect_word(input logic [31:0] w);
        logic v;
        v = w[0];
        return {3'b000, w[28:10], w[9:4], 2'b00, w[1] & v, v};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests = n_tests + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic fe, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] wd);
        bus_req   = 1'b1;
        bus_write = wr;
        bus_fetch = fe;
        bus_size  = sz;
        bus_addr  = a;
        bus_wdata = wd;
        @(negedge clk);
        bus_req   = 1'b0;
        bus_write = 1'b0;
        bus_fetch = 1'b0;
        bus_size  = 2'b10;
    endtask

    task automatic read_expect(input string req, input logic [31:0] a, input logic [31:0] exp);
        access(1'b0, 1'b0, 2'b10, a, '0);
        check({req, " ready"}, {31'd0, bus_ready}, 32'd1);
        check({req, " err"}, {31'd0, bus_err}, 32'd0);
        check({req, " rdata"}, bus_rdata, exp);
    endtask

    task automatic write_clean(input string req, input logic [31:0] a, input logic [31:0] wd);
        access(1'b1, 1'b0, 2'b10, a, wd);
        check({req, " write ready"}, {31'd0, bus_ready}, 32'd1);
        check({req, " write err"}, {31'd0, bus_err}, 32'd0);
        check({req, " no wb_req"}, {31'd0, wb_req}, 32'd0);
    endtask

    task automatic t_reset;
        check("R1 ready low", {31'd0, bus_ready}, 32'd0);
        check("R1 err low", {31'd0, bus_err}, 32'd0);
        check("R1 wb_req low", {31'd0, wb_req}, 32'd0);
        read_expect("R1 way3 idx255", taddr(2'd3, 8'd255, 1'b0), 32'd0);
        read_expect("R1 way0 idx0", taddr(2'd0, 8'd0, 1'b0), 32'd0);
    endtask

    task automatic t_basic;
        for (int w = 0; w < 4; w++) begin
            write_clean("R5", taddr(2'(w), 8'd5, 1'b0), {19'h1A5 + 19'(w), 3'b000, 6'(w * 9), 4'b0001} | (32'h1 << (10 + w)));
        end
        for (int w = 0; w < 4; w++) begin
            logic [31:0] wd;
            wd = {19'h1A5 + 19'(w), 3'b000, 6'(w * 9), 4'b0001} | (32'h1 << (10 + w));
            read_expect("R4 way select", taddr(2'(w), 8'd5, 1'b0), expect_word(wd));
            read_expect("R4 A bit ignored", taddr(2'(w), 8'd5, 1'b1), expect_word(wd));
        end
    endtask

    task automatic t_field_rules;
        write_clean("R6", taddr(2'd1, 8'd77, 1'b0), 32'hFFFF_FC31);
        read_expect("R6 top tag bits zero", taddr(2'd1, 8'd77, 1'b0), 32'h1FFF_FC31);
        write_clean("R7", taddr(2'd2, 8'd78, 1'b0), 32'h0ABC_0402);
        read_expect("R7 V=0 clears U", taddr(2'd2, 8'd78, 1'b0), 32'h0ABC_0400);
    endtask

    task automatic t_errors;
        logic [31:0] a;
        a = taddr(2'd0, 8'd5, 1'b0);
        access(1'b1, 1'b0, 2'b01, a, 32'h0000_0403);
        check("R3 word size err", {30'd0, bus_ready, bus_err}, 32'd3);
        access(1'b0, 1'b0, 2'b00, a, '0);
        check("R3 byte size err", {30'd0, bus_ready, bus_err}, 32'd3);
        access(1'b1, 1'b0, 2'b11, a, 32'h0000_0403);
        check("R3 reserved size err", {30'd0, bus_ready, bus_err}, 32'd3);
        access(1'b0, 1'b1, 2'b10, a, '0);
        check("R3 fetch err", {30'd0, bus_ready, bus_err}, 32'd3);
        access(1'b1, 1'b0, 2'b10, taddr(2'd0, 8'd5, 1'b1), 32'h0000_0403);
        check("R8 assoc write err", {30'd0, bus_ready, bus_err}, 32'd3);
        read_expect("R3 R8 entry unchanged", a, expect_word({19'h1A5, 3'b000, 6'd0, 4'b0001} | 32'h400));
    endtask

    task automatic t_window;
        access(1'b1, 1'b0, 2'b10, {8'hF1, 24'h000050}, 32'h0000_0403);
        check("R2 data window no ready", {31'd0, bus_ready}, 32'd0);
        access(1'b1, 1'b0, 2'b10, {8'h00, 24'h000050}, 32'h0000_0403);
        check("R2 other space no ready", {31'd0, bus_ready}, 32'd0);
        @(negedge clk);
        check("R2 still no ready", {31'd0, bus_ready}, 32'd0);
        read_expect("R2 entry unchanged", taddr(2'd0, 8'd5, 1'b0), expect_word({19'h1A5, 3'b000, 6'd0, 4'b0001} | 32'h400));
    endtask

    task automatic t_writeback;
        logic [31:0] a, old_w, new_w;
        a     = taddr(2'd2, 8'd9, 1'b0);
        old_w = 32'h0123_4573;
        new_w = 32'h0765_4321;
        write_clean("R5 dirty setup", a, old_w);
        access(1'b1, 1'b0, 2'b10, a, new_w);
        check("R9 wb_req raised", {31'd0, wb_req}, 32'd1);
        check("R9 ready held", {31'd0, bus_ready}, 32'd0);
        check("R9 wb_tag", {10'd0, wb_tag}, {13'd0, old_w[28:10]});
        check("R9 wb_index", {24'd0, wb_index}, 32'd9);
        check("R9 wb_way", {30'd0, wb_way}, 32'd2);
        access(1'b0, 1'b0, 2'b10, taddr(2'd0, 8'd5, 1'b0), '0);
        check("R11 strobe ignored", {31'd0, bus_ready}, 32'd0);
        repeat (2) @(negedge clk);
        check("R9 still waiting", {30'd0, wb_req, bus_ready}, 32'd2);
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
        check("R10 wb_req dropped", {31'd0, wb_req}, 32'd0);
        check("R10 no ready yet", {31'd0, bus_ready}, 32'd0);
        @(negedge clk);
        check("R10 ready after ack", {30'd0, bus_ready, bus_err}, 32'd2);
        @(negedge clk);
        check("R11 no late response", {31'd0, bus_ready}, 32'd0);
        read_expect("R10 entry updated", a, expect_word(new_w));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_field_rules();
        t_errors();
        t_window();
        t_writeback();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule